// File: doc/BRIEF.md
# Composite Pixel Timing Generator

This block produces the raster timing and the serial colour stream for a single-wire, composite-compatible digital video output. It runs from a fast system clock and advances one subpixel per tick. It counts subpixels within a pixel, pixels within a line and lines within a frame, and drives a horizontal sync level and a blanking flag in their windows. Each line holds 200 pixel slots. The first 160 slots are active. Then come 15 slots of front porch, 15 slots of sync and 10 slots of back porch.

For each active pixel the block raises a request one subpixel period ahead and names the pixel by column and line. A frame buffer answers with a byte, and the block latches that byte when the request period ends. The six low colour bits go out as three 2-bit symbols, most significant pair first. Outside the active area the symbol is forced to black.

A rate input selects one of two line rates. In the normal rate each subpixel lasts two clocks. In the double rate it lasts one clock, so a line takes half the time and keeps the same slot counts.

Top module: `composite_pixel_timing`

## Requirements
- R1: A synchronous active-low reset clears all counters to subpixel 0, pixel 0, line 0 and clears the latched colour. While reset is held and in the first cycle after it, the block shows sym_o = 2'b00, sync_o = 0, blank_o = 0 and pix_req = 0.
- R2: During an active pixel, sym_o carries latched byte bits [5:4] in subpixel 0, bits [3:2] in subpixel 1 and bits [1:0] in subpixel 2. Bits [7:6] have no effect.
- R3: Pixel slots within a line are numbered 0 to 199. Slots 0 to 159 are active, 160 to 174 are front porch, 175 to 189 are sync and 190 to 199 are back porch. sync_o is 1 exactly in slots 175 to 189, on every line.
- R4: blank_o is 1 in every slot from 160 to 199, and on every line at or beyond LINES_ACTIVE. While blank_o is 1, sym_o is the black code 2'b00.
- R5: pix_req is 1 for exactly the subpixel period before each active pixel, which is subpixel 2 of the previous slot. During that period req_x and req_line give the column and line of the coming pixel. The byte on pix_byte at the clock edge that ends the period is the one displayed.
- R6: After slot 199 the line count advances. After line LINES_TOTAL-1 it wraps to line 0, so the request for pixel 0 of line 0 is raised during the last slot of the frame.
- R7: With fast_line = 1 the block advances one subpixel on every clock. With fast_line = 0 it advances on alternate clocks. A change of fast_line applies from the next clock edge.
- R8: A value on pix_byte outside a request period has no effect on sym_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the normal subpixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_line | input | 1 | 1 selects the double line rate (one clock per subpixel) |
| pix_byte | input | BYTE_W | Pixel byte returned for the current request |
| pix_req | output | 1 | High during the subpixel period before an active pixel |
| req_x | output | PIX_W | Column of the requested pixel |
| req_line | output | LINE_W | Line of the requested pixel |
| sym_o | output | SYM_W | Current 2-bit colour symbol |
| sync_o | output | 1 | Horizontal sync level |
| blank_o | output | 1 | High outside the active picture |

## Verification
All outputs come from registered counter state, so each output changes one edge after the tick that moves the counters. A latched byte shows up on sym_o in the same cycle as the pixel it belongs to. The bench steps a reference model of the counters, the tick phase and the latch once per rising edge, using the same inputs it drove before that edge. It compares every output at the following falling edge, so each check samples exactly one register stage after its cause. The rate changes at random and a reset is applied in the middle of the run, so the model and the block must agree on the tick cadence and on the recovery from reset.

// File: rtl/cpt_pkg.sv
// Package: shared constants and helpers for the composite pixel timing block.
// Assumes colour symbols are 2 bits wide and that black is the all-zero code.
package cpt_pkg;
    localparam int SYM_BITS = 2;
    localparam logic [SYM_BITS-1:0] BLACK_SYM = '0;

    // Width of an index able to count to n-1, at least 1 bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cpt_rate_tick.sv
// Module: cpt_rate_tick
// Makes the subpixel advance strobe. In double-rate mode it strobes on every clock.
// Otherwise it strobes on alternate clocks.
// Assumes the clock runs at twice the normal subpixel rate.
module cpt_rate_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_line,
    output logic tick
);
    logic phase;

    // Phase toggles in normal mode and stays cleared in double-rate mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else begin
            phase <= fast_line ? 1'b0 : ~phase;
        end
    end

    // The strobe is high every clock in fast mode and on odd phase otherwise.
    assign tick = fast_line | phase;
endmodule

// File: rtl/cpt_raster_counters.sv
// Module: cpt_raster_counters
// Nested subpixel, pixel and line counters that advance on tick.
// It also gives the position that follows the current pixel, for prefetching.
// Assumes SUBS >= 1, PIX_TOTAL >= 2, LINES_TOTAL >= 2.
module cpt_raster_counters #(
    parameter int SUBS        = 3,
    parameter int PIX_TOTAL   = 200,
    parameter int LINES_TOTAL = 525,
    localparam int SUB_W  = cpt_pkg::idx_w(SUBS),
    localparam int PIX_W  = cpt_pkg::idx_w(PIX_TOTAL),
    localparam int LINE_W = cpt_pkg::idx_w(LINES_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [SUB_W-1:0]  sub_cnt,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              last_sub,
    output logic [PIX_W-1:0]  nxt_pix,
    output logic [LINE_W-1:0] nxt_line
);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(SUBS - 1);
    localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIX_TOTAL - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_TOTAL - 1);

    // Find the pixel and line that follow the current pixel slot.
    always_comb begin
        last_sub = (sub_cnt == SUB_LAST);
        nxt_pix  = (pix_cnt == PIX_LAST) ? '0 : pix_cnt + 1'b1;
        if (pix_cnt == PIX_LAST) begin
            nxt_line = (line_cnt == LINE_LAST) ? '0 : line_cnt + 1'b1;
        end else begin
            nxt_line = line_cnt;
        end
    end

    // Advance the nested counters once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_cnt  <= '0;
            pix_cnt  <= '0;
            line_cnt <= '0;
        end else if (tick) begin
            if (last_sub) begin
                sub_cnt  <= '0;
                pix_cnt  <= nxt_pix;
                line_cnt <= nxt_line;
            end else begin
                sub_cnt  <= sub_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpt_symbol_select.sv
// Module: cpt_symbol_select
// Holds the colour bits of the current pixel and picks one symbol per subpixel.
// The most significant pair goes out first. Outside the active area it gives black.
// Assumes COLOR_BITS == SUBS * SYM_W.
module cpt_symbol_select #(
    parameter int COLOR_BITS = 6,
    parameter int SYM_W      = 2,
    localparam int SUBS  = COLOR_BITS / SYM_W,
    localparam int SUB_W = cpt_pkg::idx_w(SUBS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [COLOR_BITS-1:0] color_in,
    input  logic [SUB_W-1:0]      sub_cnt,
    input  logic                  active,
    output logic [SYM_W-1:0]      sym
);
    logic [COLOR_BITS-1:0] color_q;

    // Capture the prefetched colour when its request period ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_q <= '0;
        end else if (load) begin
            color_q <= color_in;
        end
    end

    // Choose the symbol for this subpixel, or black when not active.
    always_comb begin
        sym = cpt_pkg::BLACK_SYM;
        for (int k = 0; k < SUBS; k++) begin
            if (sub_cnt == SUB_W'(k)) begin
                sym = color_q[COLOR_BITS-1-k*SYM_W -: SYM_W];
            end
        end
        if (!active) begin
            sym = cpt_pkg::BLACK_SYM;
        end
    end
endmodule

// File: rtl/composite_pixel_timing.sv
// Module: composite_pixel_timing (top)
// Raster timing and pixel serialiser for a single-wire composite digital output.
// It decodes the active, porch and sync windows from the counters. It requests each
// active pixel one subpixel ahead and sends its colour as SUBS symbols.
// Assumes the slot windows are laid out active, front porch, sync, back porch.
module composite_pixel_timing #(
    parameter int PIX_ACTIVE   = 160,
    parameter int FRONT_PORCH  = 15,
    parameter int SYNC_SLOTS   = 15,
    parameter int BACK_PORCH   = 10,
    parameter int LINES_TOTAL  = 525,
    parameter int LINES_ACTIVE = 480,
    parameter int COLOR_BITS   = 6,
    parameter int SYM_W        = 2,
    parameter int BYTE_W       = 8,
    localparam int PIX_TOTAL = PIX_ACTIVE + FRONT_PORCH + SYNC_SLOTS + BACK_PORCH,
    localparam int SUBS      = COLOR_BITS / SYM_W,
    localparam int SUB_W     = cpt_pkg::idx_w(SUBS),
    localparam int PIX_W     = cpt_pkg::idx_w(PIX_TOTAL),
    localparam int LINE_W    = cpt_pkg::idx_w(LINES_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_line,
    input  logic [BYTE_W-1:0] pix_byte,
    output logic              pix_req,
    output logic [PIX_W-1:0]  req_x,
    output logic [LINE_W-1:0] req_line,
    output logic [SYM_W-1:0]  sym_o,
    output logic              sync_o,
    output logic              blank_o
);
    localparam logic [PIX_W-1:0]  ACT_END  = PIX_W'(PIX_ACTIVE);
    localparam logic [PIX_W-1:0]  SYNC_BEG = PIX_W'(PIX_ACTIVE + FRONT_PORCH);
    localparam logic [PIX_W-1:0]  SYNC_FIN = PIX_W'(PIX_ACTIVE + FRONT_PORCH + SYNC_SLOTS);
    localparam logic [LINE_W-1:0] LINE_ACT = LINE_W'(LINES_ACTIVE);

    logic              tick;
    logic [SUB_W-1:0]  sub_cnt;
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              last_sub;
    logic [PIX_W-1:0]  nxt_pix;
    logic [LINE_W-1:0] nxt_line;
    logic              active;
    logic              unused_hi_bits;

    cpt_rate_tick u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_line (fast_line),
        .tick      (tick)
    );

    cpt_raster_counters #(
        .SUBS        (SUBS),
        .PIX_TOTAL   (PIX_TOTAL),
        .LINES_TOTAL (LINES_TOTAL)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .sub_cnt  (sub_cnt),
        .pix_cnt  (pix_cnt),
        .line_cnt (line_cnt),
        .last_sub (last_sub),
        .nxt_pix  (nxt_pix),
        .nxt_line (nxt_line)
    );

    // Decode the picture area, the sync window and the prefetch request.
    always_comb begin
        active   = (pix_cnt < ACT_END) && (line_cnt < LINE_ACT);
        blank_o  = ~active;
        sync_o   = (pix_cnt >= SYNC_BEG) && (pix_cnt < SYNC_FIN);
        pix_req  = last_sub && (nxt_pix < ACT_END) && (nxt_line < LINE_ACT);
        req_x    = nxt_pix;
        req_line = nxt_line;
    end

    // The byte bits above the colour field are never displayed.
    assign unused_hi_bits = ^pix_byte[BYTE_W-1:COLOR_BITS];

    cpt_symbol_select #(
        .COLOR_BITS (COLOR_BITS),
        .SYM_W      (SYM_W)
    ) u_sym (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tick & pix_req),
        .color_in (pix_byte[COLOR_BITS-1:0]),
        .sub_cnt  (sub_cnt),
        .active   (active),
        .sym      (sym_o)
    );
endmodule

// File: rtl/cpt_checker.sv
// Module: cpt_checker
// Assertion checker for composite_pixel_timing, attached with bind.
module cpt_checker #(
    parameter int PIX_TOTAL   = 200,
    parameter int LINES_TOTAL = 525,
    parameter int SUB_W       = 2,
    parameter int PIX_W       = 8,
    parameter int LINE_W      = 10,
    parameter int SYM_W       = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fast_line,
    input logic              pix_req,
    input logic              sync_o,
    input logic              blank_o,
    input logic [SYM_W-1:0]  sym_o,
    input logic [SUB_W-1:0]  sub_cnt,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt
);
    // R4: the symbol is black whenever the picture is blanked.
    p_black_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blank_o |-> (sym_o == '0));

    // R3: the sync window lies inside the blanking interval.
    p_sync_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> blank_o);

    // R5: at double rate a request lasts a single clock.
    p_req_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_req && fast_line) |=> !pix_req);

    // R3: the pixel counter stays within the line.
    p_pix_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt < PIX_W'(PIX_TOTAL));

    // R6: the line counter stays within the frame.
    p_line_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_cnt < LINE_W'(LINES_TOTAL));

    // R7: at normal rate the subpixel never advances on two clocks in a row.
    p_slow_cadence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sub_cnt) && $past(!fast_line) && !fast_line) |=> $stable(sub_cnt));
endmodule

bind composite_pixel_timing cpt_checker #(
    .PIX_TOTAL   (PIX_TOTAL),
    .LINES_TOTAL (LINES_TOTAL),
    .SUB_W       (SUB_W),
    .PIX_W       (PIX_W),
    .LINE_W      (LINE_W),
    .SYM_W       (SYM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_line (fast_line),
    .pix_req   (pix_req),
    .sync_o    (sync_o),
    .blank_o   (blank_o),
    .sym_o     (sym_o),
    .sub_cnt   (sub_cnt),
    .pix_cnt   (pix_cnt),
    .line_cnt  (line_cnt)
);

// File: tb/tb_composite_pixel_timing.sv
// Bench for composite_pixel_timing: random rate, random bytes, directed corner bytes,
// a reset in the middle of the run, and a reference model stepped once per rising edge.
module tb_composite_pixel_timing;
    localparam int CLK_PERIOD = 10;
    localparam int LT   = 12;
    localparam int LA   = 8;
    localparam int NCYC = 40000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fast_line;
    logic [7:0] pix_byte;
    logic       pix_req;
    logic [7:0] req_x;
    logic [3:0] req_line;
    logic [1:0] sym_o;
    logic       sync_o;
    logic       blank_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // reference model state
    int m_sub, m_pix, m_line, m_lat, m_ph;

    always #(CLK_PERIOD/2) clk = ~clk;

    composite_pixel_timing #(.LINES_TOTAL(LT), .LINES_ACTIVE(LA)) dut (
        .clk(clk), .rst_n(rst_n), .fast_line(fast_line), .pix_byte(pix_byte),
        .pix_req(pix_req), .req_x(req_x), .req_line(req_line),
        .sym_o(sym_o), .sync_o(sync_o), .blank_o(blank_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (pix %0d line %0d sub %0d)",
                     tag, act, exp, m_pix, m_line, m_sub);
        end
    endtask

    function automatic bit exp_active();
        return (m_pix < 160) && (m_line < LA);
    endfunction

    // R2: symbol k carries bits [5-2k:4-2k]; black outside active area (R4).
    function automatic int exp_sym();
        if (!exp_active()) return 0;
        return (m_lat >> (2 * (2 - m_sub))) & 3;
    endfunction

    function automatic int exp_npix();
        return (m_pix == 199) ? 0 : m_pix + 1;
    endfunction

    function automatic int exp_nline();
        if (m_pix != 199) return m_line;
        return (m_line == LT - 1) ? 0 : m_line + 1;
    endfunction

    function automatic bit exp_req();
        return (m_sub == 2) && (exp_npix() < 160) && (exp_nline() < LA);
    endfunction

    task automatic model_reset();
        m_sub = 0; m_pix = 0; m_line = 0; m_lat = 0; m_ph = 0;
    endtask

    task automatic check_outputs();
        chk(sym_o == 2'(exp_sym()), exp_active() ? "R2 R7 R8 symbol" : "R4 black symbol",
            int'(sym_o), exp_sym());
        chk(sync_o == ((m_pix >= 175) && (m_pix < 190)), "R3 sync window",
            int'(sync_o), int'((m_pix >= 175) && (m_pix < 190)));
        chk(blank_o == !exp_active(), "R4 blank", int'(blank_o), int'(!exp_active()));
        chk(pix_req == exp_req(), "R5 request", int'(pix_req), int'(exp_req()));
        if (exp_req()) begin
            chk(int'(req_x) == exp_npix(), "R5 request column", int'(req_x), exp_npix());
            chk(int'(req_line) == exp_nline(), "R6 request line", int'(req_line), exp_nline());
        end
    endtask

    initial begin
        int nreq;
        nreq      = 0;
        rst_n     = 1'b0;
        fast_line = 1'b0;
        pix_byte  = 8'h00;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(sym_o == 2'b00, "R1 reset symbol", int'(sym_o), 0);
        chk(sync_o == 1'b0, "R1 reset sync", int'(sync_o), 0);
        chk(blank_o == 1'b0, "R1 reset blank", int'(blank_o), 0);
        chk(pix_req == 1'b0, "R1 reset request", int'(pix_req), 0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            // stimulus for the coming edge
            rst_n = !(cyc == 20000 || cyc == 20001);
            if (cyc < 8000) fast_line = 1'b1;            // directed fast stretch (R7)
            else if (cyc < 16000) fast_line = 1'b0;      // directed slow stretch (R7)
            else if ($urandom_range(0, 499) == 0) fast_line = ~fast_line;
            if (exp_req() && nreq < 4) begin
                // directed corner bytes: all ones, only ignored bits, 01/10/11 order
                case (nreq)
                    0: pix_byte = 8'hFF;
                    1: pix_byte = 8'hC0;
                    2: pix_byte = 8'h1B;
                    default: pix_byte = 8'h24;
                endcase
            end else begin
                // R8: bytes outside requests are random junk that must be ignored
                pix_byte = 8'($urandom());
            end
            @(posedge clk);
            // model step for this edge
            if (!rst_n) begin
                model_reset();
            end else begin
                bit tk;
                tk = fast_line || (m_ph != 0);
                if (tk && exp_req()) begin
                    m_lat = int'(pix_byte[5:0]);
                    nreq++;
                end
                m_ph = fast_line ? 0 : (m_ph == 0 ? 1 : 0);
                if (tk) begin
                    if (m_sub == 2) begin
                        int np, nl;
                        np = exp_npix();
                        nl = exp_nline();
                        m_sub = 0; m_pix = np; m_line = nl;
                    end else begin
                        m_sub++;
                    end
                end
            end
            @(negedge clk);
            if (cyc == 20001) begin
                // R1: state right after a mid-run reset
                chk(pix_req == 1'b0 && blank_o == 1'b0 && sym_o == 2'b00, "R1 mid-run reset",
                    int'({pix_req, blank_o, sym_o}), 0);
            end
            check_outputs();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule